// File: doc/BRIEF.md
# Extended-Address Three-Level Page Walker

This block turns a 32-bit linear address into a 36-bit physical address. It reads translation entries from memory in a hierarchy of up to three levels. The first level is a four-entry pointer table. The second level is a 512-entry directory. The third level is a 512-entry page table. Every entry is 64 bits wide, and every table base or frame base it holds is a 24-bit frame number. A directory entry whose size flag is set ends the walk early and maps a 2 MB page. Otherwise the walk goes on to a page-table entry and maps a 4 KB page.

A requester offers one linear address together with its access kind: write or read, and user or supervisor. The walker takes the request only while it is idle. It then issues one 64-bit memory read per level, with a single read outstanding at a time. It returns either the physical address or a fault code. The result stays valid until the requester acknowledges it.

An enable input models the control bit that switches on extended addressing. While that input is low, a request is answered at once with the zero-extended linear address and no memory traffic. The pointer-table frame comes from a base-register input. One base setting therefore reaches at most 4 GB of the 36-bit space.

The state machine has four states:
- `S_IDLE` waits for a request.
- `S_ISSUE` presents a memory read.
- `S_WAIT` waits for the read data and evaluates the entry.
- `S_DONE` holds the response.

It has these transitions:
- Accept: `S_IDLE` to `S_ISSUE`, when enabled.
- Bypass: `S_IDLE` to `S_DONE`, when disabled.
- Granted: `S_ISSUE` to `S_WAIT`, when the read is accepted.
- Descend: `S_WAIT` to `S_ISSUE`, to read the next level.
- Finish: `S_WAIT` to `S_DONE`, on a mapping or a fault.
- Release: `S_DONE` to `S_IDLE`, on acknowledge.

Top module: `xpw_walker`

## Requirements
- R1: A 4 KB mapping gives the physical address `{pte[35:12], laddr[11:0]}` after exactly three memory reads. Entry bits 63:36 are ignored.
- R2: Each read address is `{table_frame, 12'h000} + index*8`, so it is always 8-byte aligned. The index is `laddr[31:30]` at the pointer level, `laddr[29:21]` at the directory level and `laddr[20:12]` at the page level. The pointer-table frame is `root_frame`.
- R3: A present and permitted directory entry with bit 7 set ends the walk after two reads. The physical address is then `{pde[35:21], laddr[20:0]}`.
- R4: An entry with bit 0 (present) clear ends the walk with code 1 at the pointer level, 2 at the directory level or 3 at the page level. The physical address is then 0. Code 0 means success.
- R5: A write meeting bit 1 clear, or a user access meeting bit 2 clear, gives code 4 at the directory level or code 5 at the page level, with physical address 0. Bits 1 and 2 of the pointer entry are ignored.
- R6: At each level the present check takes precedence over the protection check. A directory-level fault issues no page-level read.
- R7: With `xlat_en` low, a request returns `{4'h0, laddr}` with code 0 and issues no memory read.
- R8: `req_ready` is high only in `S_IDLE`. The response stays valid and stable until `rsp_ack`, and the block is idle in the cycle after acknowledge.
- R9: A read request holds its valid and address until `mem_rd_ready`. A stalled memory still yields a correct translation.
- R10: A synchronous `rst` returns the block to `S_IDLE` from any state, with no read or response pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xlat_en | input | 1 | Extended-address translation enable |
| root_frame | input | 24 | Frame number of the pointer table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting |
| req_laddr | input | 32 | Linear address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user access |
| mem_rd_valid | output | 1 | Memory read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 36 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ack | input | 1 | Requester takes the result |
| rsp_paddr | output | 36 | Physical address, 0 on fault |
| rsp_code | output | 3 | Fault code (0 none, 1 to 3 not present, 4 to 5 protection) |

## Verification
The assertions assume that memory returns exactly one `mem_rsp_valid` pulse per accepted read, and only after that read is accepted. They also assume that `rsp_ack` is raised only while a response is valid. The bench memory model answers each accepted read one cycle later with a single pulse, and returns zero for unmapped addresses. The requester tasks raise acknowledge only after they have seen `rsp_valid` and checked that it holds. Stalls come from a ready-throttling mode of the memory model, never from withheld or duplicated data.

// File: rtl/xpw_pkg.sv
package xpw_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_DONE  = 2'd3
    } walk_state_e;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_NP_PTR   = 3'd1,
        FLT_NP_DIR   = 3'd2,
        FLT_NP_PT    = 3'd3,
        FLT_PROT_DIR = 3'd4,
        FLT_PROT_PT  = 3'd5
    } walk_fault_e;

    localparam int FLAG_PRESENT = 0;
    localparam int FLAG_WRITE   = 1;
    localparam int FLAG_USER    = 2;
    localparam int FLAG_BIG     = 7;
endpackage

// File: rtl/xpw_entry_addr.sv
module xpw_entry_addr #(
    parameter int LA_W   = 32,
    parameter int PA_W   = 36,
    parameter int PG_OFF = 12,
    parameter int IDX_W  = 9,
    parameter int ENT_SH = 3
) (
    input  logic [PA_W-PG_OFF-1:0] base_frame,
    input  logic [1:0]             lvl,
    input  logic [LA_W-1:PG_OFF]   vpn,
    output logic [PA_W-1:0]        addr
);
    localparam int TOP_W = LA_W - PG_OFF - 2*IDX_W;

    logic [IDX_W-1:0] idx;

    always_comb begin
        unique case (lvl)
            2'd0:    idx = IDX_W'(vpn[LA_W-1 -: TOP_W]);
            2'd1:    idx = vpn[PG_OFF+2*IDX_W-1 -: IDX_W];
            default: idx = vpn[PG_OFF+IDX_W-1 -: IDX_W];
        endcase
    end

    assign addr = {base_frame, {PG_OFF{1'b0}}} + (PA_W'(idx) << ENT_SH);
endmodule

// File: rtl/xpw_entry_eval.sv
module xpw_entry_eval
    import xpw_pkg::*;
#(
    parameter int PA_W   = 36,
    parameter int ENT_W  = 64,
    parameter int PG_OFF = 12
) (
    input  logic [ENT_W-1:0]       entry,
    input  logic                   at_dir,
    input  logic                   is_write,
    input  logic                   is_user,
    output logic                   present,
    output logic                   allowed,
    output logic                   big,
    output logic [PA_W-PG_OFF-1:0] frame
);
    logic unused_bits;
    assign unused_bits = ^{entry[ENT_W-1:PA_W], entry[PG_OFF-1:FLAG_BIG+1], entry[FLAG_BIG-1:FLAG_USER+1]};

    assign present = entry[FLAG_PRESENT];
    assign allowed = (!is_write || entry[FLAG_WRITE]) && (!is_user || entry[FLAG_USER]);
    assign big     = at_dir && entry[FLAG_BIG];
    assign frame   = entry[PA_W-1:PG_OFF];
endmodule

// File: rtl/xpw_walker.sv
module xpw_walker
    import xpw_pkg::*;
#(
    parameter int LA_W   = 32,
    parameter int PA_W   = 36,
    parameter int ENT_W  = 64,
    parameter int PG_OFF = 12,
    parameter int IDX_W  = 9
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   xlat_en,
    input  logic [PA_W-PG_OFF-1:0] root_frame,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [LA_W-1:0]        req_laddr,
    input  logic                   req_write,
    input  logic                   req_user,
    output logic                   mem_rd_valid,
    input  logic                   mem_rd_ready,
    output logic [PA_W-1:0]        mem_rd_addr,
    input  logic                   mem_rsp_valid,
    input  logic [ENT_W-1:0]       mem_rsp_data,
    output logic                   rsp_valid,
    input  logic                   rsp_ack,
    output logic [PA_W-PG_OFF+PG_OFF-1:0] rsp_paddr,
    output logic [2:0]             rsp_code
);
    localparam int FRAME_W   = PA_W - PG_OFF;
    localparam int LARGE_OFF = PG_OFF + IDX_W;

    walk_state_e         st, st_n;
    walk_fault_e         code_q, code_n;
    logic [1:0]          lvl, lvl_n;
    logic [FRAME_W-1:0]  base_q, base_n;
    logic [LA_W-1:0]     laddr_q, laddr_n;
    logic                wr_q, wr_n, usr_q, usr_n;
    logic [PA_W-1:0]     paddr_q, paddr_n;

    logic                e_present, e_allowed, e_big;
    logic [FRAME_W-1:0]  e_frame;

    xpw_entry_addr #(.LA_W(LA_W), .PA_W(PA_W), .PG_OFF(PG_OFF), .IDX_W(IDX_W)) u_addr (
        .base_frame (base_q),
        .lvl        (lvl),
        .vpn        (laddr_q[LA_W-1:PG_OFF]),
        .addr       (mem_rd_addr)
    );

    xpw_entry_eval #(.PA_W(PA_W), .ENT_W(ENT_W), .PG_OFF(PG_OFF)) u_eval (
        .entry    (mem_rsp_data),
        .at_dir   (lvl == 2'd1),
        .is_write (wr_q),
        .is_user  (usr_q),
        .present  (e_present),
        .allowed  (e_allowed),
        .big      (e_big),
        .frame    (e_frame)
    );

    // Next-state and walk datapath
    always_comb begin
        st_n    = st;
        lvl_n   = lvl;
        base_n  = base_q;
        laddr_n = laddr_q;
        wr_n    = wr_q;
        usr_n   = usr_q;
        paddr_n = paddr_q;
        code_n  = code_q;
        unique case (st)
            S_IDLE: begin
                if (req_valid) begin
                    laddr_n = req_laddr;
                    wr_n    = req_write;
                    usr_n   = req_user;
                    code_n  = FLT_NONE;
                    lvl_n   = 2'd0;
                    if (xlat_en) begin
                        base_n  = root_frame;
                        paddr_n = '0;
                        st_n    = S_ISSUE;
                    end else begin
                        paddr_n = PA_W'(req_laddr);
                        st_n    = S_DONE;
                    end
                end
            end
            S_ISSUE: begin
                if (mem_rd_ready) st_n = S_WAIT;
            end
            S_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!e_present) begin
                        code_n  = (lvl == 2'd0) ? FLT_NP_PTR :
                                  (lvl == 2'd1) ? FLT_NP_DIR : FLT_NP_PT;
                        paddr_n = '0;
                        st_n    = S_DONE;
                    end else if (lvl == 2'd0) begin
                        base_n = e_frame;
                        lvl_n  = 2'd1;
                        st_n   = S_ISSUE;
                    end else if (!e_allowed) begin
                        code_n  = (lvl == 2'd1) ? FLT_PROT_DIR : FLT_PROT_PT;
                        paddr_n = '0;
                        st_n    = S_DONE;
                    end else if (e_big) begin
                        paddr_n = {e_frame[FRAME_W-1:IDX_W], laddr_q[LARGE_OFF-1:0]};
                        st_n    = S_DONE;
                    end else if (lvl == 2'd1) begin
                        base_n = e_frame;
                        lvl_n  = 2'd2;
                        st_n   = S_ISSUE;
                    end else begin
                        paddr_n = {e_frame, laddr_q[PG_OFF-1:0]};
                        st_n    = S_DONE;
                    end
                end
            end
            S_DONE: begin
                if (rsp_ack) st_n = S_IDLE;
            end
            default: st_n = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            lvl     <= 2'd0;
            base_q  <= '0;
            laddr_q <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            paddr_q <= '0;
            code_q  <= FLT_NONE;
        end else begin
            st      <= st_n;
            lvl     <= lvl_n;
            base_q  <= base_n;
            laddr_q <= laddr_n;
            wr_q    <= wr_n;
            usr_q   <= usr_n;
            paddr_q <= paddr_n;
            code_q  <= code_n;
        end
    end

    // Outputs
    always_comb begin
        req_ready    = (st == S_IDLE);
        mem_rd_valid = (st == S_ISSUE);
        rsp_valid    = (st == S_DONE);
        rsp_paddr    = paddr_q;
        rsp_code     = code_q;
    end

    assert_rd_align_R2: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> (mem_rd_addr[2:0] == 3'd0));

    assert_fault_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code != 3'd0) |-> (rsp_paddr == '0));

    assert_code_range_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_code <= 3'd5));

    assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ack) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_code)));

    assert_idle_excl_R8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!rsp_valid && !mem_rd_valid));

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    assert_rst_idle_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !mem_rd_valid && !rsp_valid));
endmodule

// File: tb/test_xpw_walker.sv
module test_xpw_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xlat_en = 1'b1;
    logic [23:0] root_frame = 24'h000010;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [31:0] req_laddr = '0;
    logic        req_ready, mem_rd_valid, mem_rd_ready;
    logic [35:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid, rsp_ack = 1'b0;
    logic [35:0] rsp_paddr;
    logic [2:0]  rsp_code;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    xpw_walker i_xpw_walker (
        .clk(clk), .rst(rst), .xlat_en(xlat_en), .root_frame(root_frame),
        .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
        .req_write(req_write), .req_user(req_user),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_paddr(rsp_paddr), .rsp_code(rsp_code)
    );

    // Memory model: answers one cycle after each accepted read
    logic [63:0] mem [logic [35:0]];
    logic [35:0] rd_log [0:63];
    int          rd_n = 0;
    bit          stall_en = 0, mem_block = 0;
    logic [1:0]  stall_ctr = '0;

    assign mem_rd_ready = !mem_block && (!stall_en || stall_ctr == 2'd3);

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_rd_valid && !mem_rd_ready) stall_ctr <= stall_ctr + 2'd1;
        else stall_ctr <= '0;
        if (mem_rd_valid && mem_rd_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 64'h0;
            rd_log[rd_n % 64] <= mem_rd_addr;
            rd_n <= rd_n + 1;
        end
    end

    function automatic logic [63:0] mk(input logic [23:0] fr, input logic [11:0] fl);
        return {28'h0, fr, fl};
    endfunction

    function automatic logic [35:0] ea(input logic [23:0] fr, input int idx);
        return {fr, 12'h000} + 36'(idx * 8);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [35:0] g_pa;
    logic [2:0]  g_code;
    int          g_reads, g_base;

    task automatic xlat(input logic [31:0] la, input bit wr, input bit us);
        int n = 0;
        @(negedge clk);
        g_base    = rd_n;
        req_valid = 1'b1; req_laddr = la; req_write = wr; req_user = us;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
        if (!rsp_valid) chk("watchdog R8", 0, 1);
        g_pa    = rsp_paddr;
        g_code  = rsp_code;
        g_reads = rd_n - g_base;
        @(negedge clk);
        chk("R8 response held", {rsp_valid, rsp_paddr, rsp_code}, {1'b1, g_pa, g_code});
        rsp_ack = 1'b1;
        @(negedge clk);
        rsp_ack = 1'b0;
        chk("R8 idle after ack", {req_ready, rsp_valid}, 2'b10);
    endtask

    localparam logic [31:0] LA_4K  = {2'b01, 9'h003, 9'h005, 12'hABC};
    localparam logic [31:0] LA_BIG = {2'b01, 9'h004, 21'h1_2345};

    task automatic t_reset();
        chk("R10 reset ready", req_ready, 1);
        chk("R10 reset no read", mem_rd_valid, 0);
        chk("R10 reset no rsp", rsp_valid, 0);
    endtask

    task automatic t_4k();
        xlat(LA_4K, 0, 0);
        chk("R1 4k paddr", g_pa, 36'hABCDE1ABC);
        chk("R1 4k code", g_code, 0);
        chk("R1 4k reads", g_reads, 3);
        chk("R2 ptr addr", rd_log[g_base % 64], ea(24'h10, 1));
        chk("R2 dir addr", rd_log[(g_base+1) % 64], ea(24'h20, 3));
        chk("R2 pt addr", rd_log[(g_base+2) % 64], ea(24'h30, 5));
        xlat(LA_4K, 1, 1);
        chk("R5 ptr flags ignored", {g_code, g_pa}, {3'd0, 36'hABCDE1ABC});
    endtask

    task automatic t_big();
        xlat(LA_BIG, 1, 1);
        chk("R3 big paddr", g_pa, {15'(24'h246800 >> 9), 21'h1_2345});
        chk("R3 big reads", g_reads, 2);
        chk("R3 big code", g_code, 0);
    endtask

    task automatic t_not_present();
        xlat({2'b10, 9'h003, 9'h005, 12'h0}, 0, 0);
        chk("R4 np ptr", {g_code, g_pa, 8'(g_reads)}, {3'd1, 36'h0, 8'd1});
        xlat({2'b01, 9'h007, 9'h005, 12'h0}, 0, 0);
        chk("R4 np dir", {g_code, g_pa, 8'(g_reads)}, {3'd2, 36'h0, 8'd2});
        xlat({2'b01, 9'h003, 9'h009, 12'h0}, 0, 0);
        chk("R4 np pt", {g_code, g_pa, 8'(g_reads)}, {3'd3, 36'h0, 8'd3});
    endtask

    task automatic t_protect();
        xlat({2'b01, 9'h008, 9'h005, 12'h123}, 1, 0);
        chk("R5 dir write prot", {g_code, g_pa}, {3'd4, 36'h0});
        chk("R6 no pt read after dir fault", g_reads, 2);
        xlat({2'b01, 9'h008, 9'h005, 12'h123}, 0, 1);
        chk("R5 dir read ok", {g_code, g_pa}, {3'd0, 36'hABCDE1123});
        xlat({2'b01, 9'h003, 9'h006, 12'h010}, 0, 1);
        chk("R5 pt user prot", {g_code, g_pa}, {3'd5, 36'h0});
        xlat({2'b01, 9'h003, 9'h006, 12'h010}, 1, 0);
        chk("R5 pt super write ok", {g_code, g_pa}, {3'd0, 36'h777777010});
        xlat({2'b01, 9'h00A, 9'h005, 12'h0}, 1, 1);
        chk("R6 present first", {g_code, 8'(g_reads)}, {3'd2, 8'd2});
    endtask

    task automatic t_disabled();
        xlat_en = 1'b0;
        xlat(32'hDEAD_BEEF, 1, 1);
        xlat_en = 1'b1;
        chk("R7 bypass paddr", {g_code, g_pa}, {3'd0, 36'h0DEADBEEF});
        chk("R7 bypass no reads", g_reads, 0);
    endtask

    task automatic t_stall();
        stall_en = 1;
        xlat(LA_4K, 0, 0);
        stall_en = 0;
        chk("R9 stalled paddr", {g_code, g_pa}, {3'd0, 36'hABCDE1ABC});
        chk("R9 stalled reads", g_reads, 3);
    endtask

    task automatic t_reset_mid();
        mem_block = 1;
        @(negedge clk);
        req_valid = 1'b1; req_laddr = LA_4K; req_write = 0; req_user = 0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9 read held while blocked", {mem_rd_valid, req_ready}, 2'b10);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        mem_block = 0;
        @(negedge clk);
        chk("R10 mid-walk reset idle", {req_ready, mem_rd_valid, rsp_valid}, 3'b100);
    endtask

    initial begin
        mem[ea(24'h10, 1)] = mk(24'h000020, 12'h001);
        mem[ea(24'h20, 3)] = mk(24'h000030, 12'h007) | 64'hFFF0_0000_0000_0000;
        mem[ea(24'h20, 4)] = mk(24'h246800, 12'h087);
        mem[ea(24'h20, 8)] = mk(24'h000030, 12'h005);
        mem[ea(24'h20, 10)] = mk(24'h000030, 12'h006);
        mem[ea(24'h30, 5)] = mk(24'hABCDE1, 12'h007) | 64'hABC0_0000_0000_0000;
        mem[ea(24'h30, 6)] = mk(24'h777777, 12'h003);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_4k();
        t_big();
        t_not_present();
        t_protect();
        t_disabled();
        t_stall();
        t_reset_mid();
        t_4k();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R8 actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule